// File: doc/BRIEF.md
# Status Flag and Branch Condition Unit

This unit sits beside an integer adder/subtractor in a simple processor core. On each cycle where the operation strobe is high, it runs one of four operations on two operands: add, subtract, compare or test. It captures a set of four status flags from that operation in a flag register: carry, sign, zero and overflow. Add and subtract also write their result to a result register and pulse a write enable. Compare (a subtraction) and test (a bitwise AND) change only the flags. They leave the result register and the write enable untouched.

A 5-bit condition selector is decoded against the registered flags to produce a branch-taken signal. The selector covers:
- single-flag tests on each flag;
- unsigned relations of a prior subtraction or compare;
- signed relations of a prior subtraction or compare;
- equality and inequality.

Branch-taken is combinational from the flag register and the selector. A branch can therefore test the flags of the operation issued on the previous cycle.

Top module: `brc_flag_unit`

## Requirements
- R1: The carry flag (flags_out bit 3) is the carry out of the most significant bit after add. After subtract or compare, it is the inverted borrow: 1 exactly when opnd_a >= opnd_b as unsigned numbers.
- R2: The sign flag (flags_out bit 2) equals the most significant bit of the operation's result.
- R3: The zero flag (flags_out bit 1) is 1 exactly when every result bit is 0.
- R4: The overflow flag (flags_out bit 0) is the XOR of the carry into and the carry out of the most significant bit. It is therefore 1 only when signed add or subtract overflows.
- R5: op_sel encodes 0 add, 1 subtract, 2 compare (opnd_a minus opnd_b), 3 test (opnd_a AND opnd_b). Add and subtract load res_data and pulse res_we high for the cycle after the strobe. Compare and test leave res_data unchanged and res_we low. Test clears carry and overflow.
- R6: While op_valid is low, the flags, res_data and res_we (low) do not change.
- R7: Single-flag codes on cond_sel: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 S=0 (plus), 5 S=1 (minus), 6 V=1, 7 V=0.
- R8: Unsigned codes: 8 higher (C=1 and Z=0), 9 higher-or-equal (C=1), 10 lower (C=0), 11 lower-or-equal (C=0 or Z=1). After a subtract or compare, these match the unsigned relation of opnd_a to opnd_b.
- R9: Codes 12 equal (Z=1) and 13 not-equal (Z=0). Signed codes: 14 greater (S XOR V = 0 and Z=0), 15 greater-or-equal (S XOR V = 0), 16 less (S XOR V = 1), 17 less-or-equal (S XOR V = 1 or Z=1). After a subtract or compare, these match the signed relation of the operands.
- R10: Codes 18 to 31 always give branch_taken = 0.
- R11: Synchronous active-high reset clears all flags, res_data and res_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | Operation: 0 add, 1 sub, 2 compare, 3 test |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| cond_sel | input | 5 | Branch condition code |
| res_data | output | DATA_W | Registered result of last add or subtract |
| res_we | output | 1 | Result write pulse |
| flags_out | output | 4 | Registered flags {C, S, Z, V} |
| branch_taken | output | 1 | Selected condition holds on current flags |

## Verification
Subtraction is swept over every operand pair, and every one of the 32 condition codes is evaluated after each operation. The relational codes are compared against direct unsigned and signed comparisons of the operands, not against flag formulas. Three kinds of error would therefore show up as wrong decisions on operand pairs near the sign boundary and near equality:
- a carry taken as borrow instead of inverted borrow;
- overflow built from the wrong carry;
- a signed condition that ignores overflow.

Compare and test operations are interleaved with add results so that a design writing the result register on those operations alters res_data. Idle cycles with changed operands expose a flag register that loads without the strobe.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_CMP = 2'd2,
        OP_TST = 2'd3
    } op_e;

    typedef struct packed {
        logic c;
        logic s;
        logic z;
        logic v;
    } flags_t;

    typedef enum logic [4:0] {
        CC_ZSET  = 5'd0,
        CC_ZCLR  = 5'd1,
        CC_CSET  = 5'd2,
        CC_CCLR  = 5'd3,
        CC_PLUS  = 5'd4,
        CC_MINUS = 5'd5,
        CC_VSET  = 5'd6,
        CC_VCLR  = 5'd7,
        CC_UHI   = 5'd8,
        CC_UHS   = 5'd9,
        CC_ULO   = 5'd10,
        CC_ULS   = 5'd11,
        CC_EQ    = 5'd12,
        CC_NE    = 5'd13,
        CC_SGT   = 5'd14,
        CC_SGE   = 5'd15,
        CC_SLT   = 5'd16,
        CC_SLE   = 5'd17
    } cond_e;

    localparam logic [4:0] LAST_CODE = 5'd17;

    function automatic logic op_writes(op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic op_subtracts(op_e op);
        return (op == OP_SUB) || (op == OP_CMP);
    endfunction

    function automatic logic cond_hit(flags_t f, logic [4:0] code);
        logic lt;
        lt = f.s ^ f.v;
        case (code)
            CC_ZSET:  return f.z;
            CC_ZCLR:  return !f.z;
            CC_CSET:  return f.c;
            CC_CCLR:  return !f.c;
            CC_PLUS:  return !f.s;
            CC_MINUS: return f.s;
            CC_VSET:  return f.v;
            CC_VCLR:  return !f.v;
            CC_UHI:   return f.c && !f.z;
            CC_UHS:   return f.c;
            CC_ULO:   return !f.c;
            CC_ULS:   return !f.c || f.z;
            CC_EQ:    return f.z;
            CC_NE:    return !f.z;
            CC_SGT:   return !lt && !f.z;
            CC_SGE:   return !lt;
            CC_SLT:   return lt;
            CC_SLE:   return lt || f.z;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/brc_flag_alu.sv
module brc_flag_alu
    import brc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output flags_t            flg
);
    localparam int MSB = DATA_W - 1;

    logic              inv;
    logic [DATA_W-1:0] bx;
    logic [DATA_W-1:0] lo_sum;
    logic [1:0]        hi_sum;
    logic              c_into_msb;
    logic [DATA_W-1:0] sum_res;
    logic [DATA_W-1:0] and_res;

    always_comb begin
        inv        = op_subtracts(op);
        bx         = inv ? ~b : b;
        lo_sum     = {1'b0, a[MSB-1:0]} + {1'b0, bx[MSB-1:0]}
                   + {{(DATA_W-1){1'b0}}, inv};
        c_into_msb = lo_sum[MSB];
        hi_sum     = {1'b0, a[MSB]} + {1'b0, bx[MSB]} + {1'b0, c_into_msb};
        sum_res    = {hi_sum[0], lo_sum[MSB-1:0]};
        and_res    = a & b;

        if (op == OP_TST) begin
            res   = and_res;
            flg.c = 1'b0;
            flg.v = 1'b0;
        end else begin
            res   = sum_res;
            flg.c = hi_sum[1];
            flg.v = hi_sum[1] ^ c_into_msb;
        end
        flg.s = res[MSB];
        flg.z = (res == '0);
    end

endmodule

// File: rtl/brc_flag_state.sv
module brc_flag_state
    import brc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              wr,
    input  logic [DATA_W-1:0] d_res,
    input  flags_t            d_flg,
    output logic [DATA_W-1:0] q_res,
    output logic              q_we,
    output flags_t            q_flg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_res <= '0;
            q_we  <= 1'b0;
            q_flg <= '0;
        end else begin
            q_we <= load && wr;
            if (load) begin
                q_flg <= d_flg;
            end
            if (load && wr) begin
                q_res <= d_res;
            end
        end
    end

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(load)) |-> ($stable(q_flg) && !q_we));

endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
(
    input  flags_t     flg,
    input  logic [4:0] code,
    output logic       taken
);
    always_comb begin
        taken = cond_hit(flg, code);
    end

endmodule

// File: rtl/brc_flag_unit.sv
module brc_flag_unit
    import brc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [4:0]        cond_sel,
    output logic [DATA_W-1:0] res_data,
    output logic              res_we,
    output logic [3:0]        flags_out,
    output logic              branch_taken
);
    localparam int MSB = DATA_W - 1;

    op_e               op;
    logic [DATA_W-1:0] alu_res;
    flags_t            alu_flg;
    flags_t            flg_q;

    assign op = op_e'(op_sel);

    brc_flag_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (alu_res),
        .flg (alu_flg)
    );

    brc_flag_state #(.DATA_W(DATA_W)) u_state (
        .clk   (clk),
        .rst   (rst),
        .load  (op_valid),
        .wr    (op_writes(op)),
        .d_res (alu_res),
        .d_flg (alu_flg),
        .q_res (res_data),
        .q_we  (res_we),
        .q_flg (flg_q)
    );

    brc_cond_eval u_cond (
        .flg   (flg_q),
        .code  (cond_sel),
        .taken (branch_taken)
    );

    assign flags_out = flg_q;

    // R1
    cmp_carry_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op_valid && op_sel == 2'd2)
        |-> (flg_q.c == ($past(opnd_a) >= $past(opnd_b))));

    // R3
    zero_res_chk: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (flg_q.z == (res_data == '0)));

    // R4
    sub_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && op_valid && op_sel == 2'd1)
        |-> (flg_q.v == (($past(opnd_a[MSB]) ^ $past(opnd_b[MSB]))
                         & (res_data[MSB] ^ $past(opnd_a[MSB])))));

    // R5
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(op_valid && !op_sel[1])) |-> ($stable(res_data) && !res_we));

    // R10
    unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_sel > LAST_CODE) |-> !branch_taken);

endmodule

// File: tb/brc_flag_unit_tb.sv
`timescale 1ns/10ps
module brc_flag_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [1:0] op_sel = 2'd0;
    logic [7:0] opnd_a = 8'd0;
    logic [7:0] opnd_b = 8'd0;
    logic [4:0] cond_sel = 5'd0;
    logic [7:0] res_data;
    logic       res_we;
    logic [3:0] flags_out;
    logic       branch_taken;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bit [7:0] last_res = 8'd0;
    bit [3:0] exp_flg  = 4'd0;

    always #2 clk = ~clk;

    brc_flag_unit #(.DATA_W(8)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .op_valid     (op_valid),
        .op_sel       (op_sel),
        .opnd_a       (opnd_a),
        .opnd_b       (opnd_b),
        .cond_sel     (cond_sel),
        .res_data     (res_data),
        .res_we       (res_we),
        .flags_out    (flags_out),
        .branch_taken (branch_taken)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic bit flag_cond(int code, bit [3:0] f);
        bit c, s, z, v, lt;
        c = f[3]; s = f[2]; z = f[1]; v = f[0]; lt = s ^ v;
        case (code)
            0: return z;        1: return !z;
            2: return c;        3: return !c;
            4: return !s;       5: return s;
            6: return v;        7: return !v;
            8: return c && !z;  9: return c;
            10: return !c;      11: return !c || z;
            12: return z;       13: return !z;
            14: return !lt && !z; 15: return !lt;
            16: return lt;      17: return lt || z;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit rel_cond(int code, bit [7:0] a, bit [7:0] b);
        case (code)
            8:  return a > b;
            9:  return a >= b;
            10: return a < b;
            11: return a <= b;
            12: return a == b;
            13: return a != b;
            14: return $signed(a) > $signed(b);
            15: return $signed(a) >= $signed(b);
            16: return $signed(a) < $signed(b);
            17: return $signed(a) <= $signed(b);
            default: return 1'b0;
        endcase
    endfunction

    function automatic string cond_tag(int code);
        if (code < 8) return "R7";
        if (code < 12) return "R8";
        if (code < 18) return "R9";
        return "R10";
    endfunction

    task automatic do_op(input bit vld, input bit [1:0] op, input bit [7:0] a, input bit [7:0] b);
        bit [8:0] wide;
        bit [7:0] r;
        bit c, v, rel;
        bit [3:0] f;
        @(negedge clk);
        op_valid = vld; op_sel = op; opnd_a = a; opnd_b = b;
        case (op)
            2'd0: begin
                wide = {1'b0, a} + {1'b0, b};
                r = wide[7:0]; c = wide[8];
                v = (a[7] == b[7]) && (r[7] != a[7]);
            end
            2'd3: begin
                r = a & b; c = 1'b0; v = 1'b0;
            end
            default: begin
                r = a - b; c = (a >= b);
                v = (a[7] != b[7]) && (r[7] != a[7]);
            end
        endcase
        f = {c, r[7], (r == 8'd0), v};
        if (vld) exp_flg = f;
        rel = vld && (op == 2'd1 || op == 2'd2);
        @(posedge clk);
        #0.5;
        chk(flags_out[3] == exp_flg[3], vld ? "R1" : "R6", flags_out[3], exp_flg[3]);
        chk(flags_out[2] == exp_flg[2], vld ? "R2" : "R6", flags_out[2], exp_flg[2]);
        chk(flags_out[1] == exp_flg[1], vld ? "R3" : "R6", flags_out[1], exp_flg[1]);
        chk(flags_out[0] == exp_flg[0], vld ? "R4" : "R6", flags_out[0], exp_flg[0]);
        if (vld && op[1] == 1'b0) last_res = r;
        chk(res_we == (vld && op[1] == 1'b0), vld ? "R5" : "R6", res_we, vld && op[1] == 1'b0);
        chk(res_data == last_res, vld ? "R5" : "R6", res_data, last_res);
        for (int k = 0; k < 32; k++) begin
            bit e;
            cond_sel = k[4:0];
            #0.04;
            e = (rel && k >= 8 && k <= 17) ? rel_cond(k, a, b) : flag_cond(k, exp_flg);
            chk(branch_taken == e, cond_tag(k), branch_taken, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #0.5;
        // R11: reset state
        chk(flags_out == 4'd0, "R11", flags_out, 0);
        chk(res_data == 8'd0, "R11", res_data, 0);
        chk(res_we == 1'b0, "R11", res_we, 0);

        // directed corners
        do_op(1, 2'd0, 8'h7F, 8'h01);
        do_op(1, 2'd0, 8'hFF, 8'h01);
        do_op(1, 2'd0, 8'h80, 8'h80);
        do_op(1, 2'd1, 8'h80, 8'h01);
        do_op(1, 2'd2, 8'h05, 8'h05);
        do_op(1, 2'd3, 8'hF0, 8'h0F);
        do_op(1, 2'd0, 8'h12, 8'h34);
        // R6: idle cycles with changed operands
        do_op(0, 2'd1, 8'h00, 8'h01);
        do_op(0, 2'd0, 8'hFF, 8'hFF);
        do_op(0, 2'd3, 8'h00, 8'h00);

        // exhaustive subtraction
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                do_op(1, 2'd1, a[7:0], b[7:0]);
        // strided add
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 7)
                do_op(1, 2'd0, a[7:0], b[7:0]);
        // compare and test interleaved with idles
        for (int a = 0; a < 256; a += 3)
            for (int b = 0; b < 256; b += 5) begin
                do_op(1, 2'd2, a[7:0], b[7:0]);
                do_op(1, 2'd3, b[7:0], a[7:0]);
                if (b % 50 == 0) do_op(0, 2'd2, b[7:0], a[7:0]);
            end

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule